// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Lock Monitor

This block keeps one shared lock word for a small bus-based multiprocessor and serves it through a single arbitrated bus. Several request ports, one per processor, can issue four kinds of operation against the word: a plain load, a plain store, a linked load and a conditional store. A linked load returns the word and sets a reservation flag for the issuing port. A conditional store writes the locked value 1 only if that port still holds its reservation. It returns 1 on success and 0 on failure. Any granted write by one port clears the reservations of the other ports. Because of this, when several processors race for a free lock, only one of their conditional stores can win.

A lock value of 0 means free and 1 means taken. A processor spins with linked loads until it reads 0, then tries a conditional store. It releases the lock with a plain store of 0. The bus is a two-state machine. In state `ST_ARB` a round-robin arbiter grants at most one requesting port. The transition *grant* (some request present) leads to `ST_EXEC`, and the transition *idle* (no request) stays in `ST_ARB`. In `ST_EXEC` the latched operation is answered on the response port and carried out at the clock edge that ends the cycle. The transition *retire* then returns unconditionally to `ST_ARB`. One operation completes every two cycles.

Top module: `lsm_lock_monitor`

## Requirements
- R1: After reset the lock word is 0, no port holds a reservation, `gnt` and `rsp_valid` are low, and the round-robin search starts at port 0.
- R2: In `ST_ARB` at most one `gnt` bit is high, and only for a port whose `req` is high. The search starts at the port after the last winner and wraps. With all ports requesting, N consecutive grants go to N distinct ports in ascending order modulo N.
- R3: The cycle after a grant, `rsp_valid` is high for exactly one cycle and `rsp_port` names the granted port, with `gnt` low. Loads, linked loads and stores return the word as it was before the operation.
- R4: A linked load (op code 2) returns the current word and sets the reservation of the issuing port.
- R5: A conditional store (op code 3) from a port holding a reservation writes 1 to the word, returns 1, and clears every port's reservation, including its own.
- R6: A conditional store from a port without a reservation, including one that never issued a linked load, returns 0 and leaves the word unchanged.
- R7: When several ports hold reservations and all issue conditional stores together, exactly one of them returns 1.
- R8: A plain store (op code 1) writes `wdata` of its port, clears the reservations of all other ports, and keeps the reservation of the issuing port.
- R9: A plain load (op code 0) changes neither the word nor any reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORT | Per-port request, held until granted |
| op | input | 2*NPORT | Per-port op code: 0 load, 1 store, 2 linked load, 3 conditional store |
| wdata | input | DATA_W*NPORT | Per-port store data |
| gnt | output | NPORT | One-hot grant, valid in `ST_ARB` |
| rsp_valid | output | 1 | Response cycle (`ST_EXEC`) |
| rsp_port | output | PORT_W | Port being answered |
| rsp_data | output | DATA_W | Prior word, or 1/0 code for a conditional store |

## Verification
The bench builds the block with NPORT=4 and DATA_W=8. Four ports are enough to race three conditional stores at once while a fourth port releases the lock, and to check that the round-robin pointer wraps from port 3 to port 0. The 8-bit word lets a plain store of 5 be told apart from the lock values 0 and 1. A behavioural model predicts the grant and the response on every clock. Directed sequences then check the outcomes of spinning, racing and release.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } bus_op_e;

    typedef enum logic {
        ST_ARB  = 1'b0,
        ST_EXEC = 1'b1
    } bus_st_e;
endpackage

// File: rtl/lsm_rr_arb.sv
module lsm_rr_arb #(
    parameter int NPORT  = 4,
    parameter int PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORT-1:0]  req,
    input  logic              advance,
    output logic [NPORT-1:0]  gnt,
    output logic [PORT_W-1:0] win,
    output logic              any
);
    logic [PORT_W-1:0] ptr_q;

    always_comb begin
        gnt = '0;
        win = '0;
        any = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            int idx;
            idx = int'(ptr_q) + i;
            if (idx >= NPORT) idx = idx - NPORT;
            if (!any && req[idx]) begin
                any      = 1'b1;
                win      = PORT_W'(idx);
                gnt[idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            if (win == PORT_W'(NPORT - 1)) ptr_q <= '0;
            else                           ptr_q <= win + 1'b1;
        end
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
endmodule

// File: rtl/lsm_resv.sv
module lsm_resv
    import lsm_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [PORT_W-1:0] port,
    input  bus_op_e           op,
    output logic [NPORT-1:0]  resv,
    output logic              hold
);
    logic [NPORT-1:0] own;

    always_comb begin
        own       = '0;
        own[port] = 1'b1;
        hold      = resv[port];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv <= '0;
        end else if (exec) begin
            unique case (op)
                OP_LOAD:  resv <= resv;
                OP_STORE: resv <= resv & own;
                OP_LINK:  resv[port] <= 1'b1;
                OP_COND:  if (hold) resv <= '0;
            endcase
        end
    end

    // R4
    ll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_LINK) |=> resv[$past(port)]);
    // R5
    sc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_COND && hold) |=> (resv == '0));
    // R9
    load_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_LOAD) |=> $stable(resv));
endmodule

// File: rtl/lsm_lock_monitor.sv
module lsm_lock_monitor
    import lsm_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int DATA_W = 8,
    localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          req,
    input  logic [2*NPORT-1:0]        op,
    input  logic [DATA_W*NPORT-1:0]   wdata,
    output logic [NPORT-1:0]          gnt,
    output logic                      rsp_valid,
    output logic [PORT_W-1:0]         rsp_port,
    output logic [DATA_W-1:0]         rsp_data
);
    bus_st_e           st_q, st_d;
    logic [NPORT-1:0]  arb_gnt;
    logic [PORT_W-1:0] arb_win;
    logic              arb_any;
    logic              take;
    logic              exec;
    logic [PORT_W-1:0] cur_port;
    bus_op_e           cur_op;
    logic [DATA_W-1:0] cur_wd;
    logic [DATA_W-1:0] lock_q;
    logic [NPORT-1:0]  resv;
    logic              hold;

    assign take = (st_q == ST_ARB) && arb_any;
    assign exec = (st_q == ST_EXEC);

    lsm_rr_arb #(.NPORT(NPORT), .PORT_W(PORT_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .advance (take),
        .gnt     (arb_gnt),
        .win     (arb_win),
        .any     (arb_any)
    );

    lsm_resv #(.NPORT(NPORT), .PORT_W(PORT_W)) u_resv (
        .clk   (clk),
        .rst_n (rst_n),
        .exec  (exec),
        .port  (cur_port),
        .op    (cur_op),
        .resv  (resv),
        .hold  (hold)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ARB:  if (arb_any) st_d = ST_EXEC;
            ST_EXEC: st_d = ST_ARB;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_ARB;
        else        st_q <= st_d;
    end

    // latch the granted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_port <= '0;
            cur_op   <= OP_LOAD;
            cur_wd   <= '0;
        end else if (take) begin
            cur_port <= arb_win;
            cur_op   <= bus_op_e'(op[2*int'(arb_win) +: 2]);
            cur_wd   <= wdata[DATA_W*int'(arb_win) +: DATA_W];
        end
    end

    // lock word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (exec) begin
            if (cur_op == OP_STORE)             lock_q <= cur_wd;
            else if (cur_op == OP_COND && hold) lock_q <= DATA_W'(1);
        end
    end

    // outputs
    always_comb begin
        gnt       = '0;
        rsp_valid = 1'b0;
        rsp_port  = cur_port;
        rsp_data  = '0;
        unique case (st_q)
            ST_ARB:  gnt = arb_gnt;
            ST_EXEC: begin
                rsp_valid = 1'b1;
                if (cur_op == OP_COND) rsp_data = {{(DATA_W-1){1'b0}}, hold};
                else                   rsp_data = lock_q;
            end
        endcase
    end

    // R2
    gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & ~req) == '0));
    // R3
    exec_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R3
    grant_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |=> (rsp_valid && gnt == '0));
    // R5
    sc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && cur_op == OP_COND && rsp_data == DATA_W'(1)) |=> (lock_q == DATA_W'(1)));
    // R6
    sc_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && cur_op == OP_COND && rsp_data == '0) |=> $stable(lock_q));
    // R9
    load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && cur_op == OP_LOAD) |=> $stable(lock_q));
endmodule

// File: tb/lsm_lock_monitor_tb.sv
module lsm_lock_monitor_tb;
    localparam int CLK_P  = 10;
    localparam int NPORT  = 4;
    localparam int DATA_W = 8;
    localparam int PORT_W = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NPORT-1:0]        req;
    logic [2*NPORT-1:0]      op;
    logic [DATA_W*NPORT-1:0] wdata;
    logic [NPORT-1:0]        gnt;
    logic                    rsp_valid;
    logic [PORT_W-1:0]       rsp_port;
    logic [DATA_W-1:0]       rsp_data;

    logic [NPORT-1:0] pend_v = '0;
    logic [1:0]       pend_op [NPORT];
    logic [7:0]       pend_wd [NPORT];
    logic [NPORT-1:0] clr = '0;

    int total = 0, bad = 0, cyc = 0;
    int m_lock, m_ptr, m_port, m_op, m_wd;
    bit m_exec;
    bit m_res [NPORT];
    int last_rsp [NPORT];
    int gq [$];

    always #(CLK_P/2) clk = ~clk;

    assign req = pend_v;
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            op[2*i +: 2]           = pend_op[i];
            wdata[DATA_W*i +: DATA_W] = pend_wd[i];
        end
    end

    lsm_lock_monitor #(.NPORT(NPORT), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .wdata(wdata),
        .gnt(gnt), .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_data(rsp_data)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // clear granted requests at the edge that takes them
    always @(posedge clk) begin
        cyc++;
        for (int i = 0; i < NPORT; i++) if (clr[i]) pend_v[i] <= 1'b0;
        clr <= '0;
        if (cyc > 100000) begin
            chk("R3 watchdog", 0, 1);
            finish_run();
        end
    end

    // reference model, compared every cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            m_lock = 0; m_ptr = 0; m_exec = 0;
            for (int i = 0; i < NPORT; i++) m_res[i] = 0;
        end else if (!m_exec) begin
            int w;
            int eg;
            w = -1;
            for (int i = 0; i < NPORT; i++) begin
                int k;
                k = (m_ptr + i) % NPORT;
                if (w < 0 && req[k]) w = k;
            end
            eg = (w < 0) ? 0 : (1 << w);
            chk("R2 grant", int'(gnt), eg);
            chk("R3 no response in arbitration", int'(rsp_valid), 0);
            if (w >= 0) begin
                m_exec = 1; m_port = w;
                m_op = int'(pend_op[w]); m_wd = int'(pend_wd[w]);
                m_ptr = (w + 1) % NPORT;
                clr[w] = 1'b1;
                gq.push_back(w);
            end
        end else begin
            int exp;
            chk("R3 response valid", int'(rsp_valid), 1);
            chk("R3 response port", int'(rsp_port), m_port);
            chk("R3 no grant in execute", int'(gnt), 0);
            exp = m_lock;
            case (m_op)
                1: begin
                    m_lock = m_wd;
                    for (int i = 0; i < NPORT; i++) if (i != m_port) m_res[i] = 0;
                end
                2: m_res[m_port] = 1;
                3: begin
                    if (m_res[m_port]) begin
                        exp = 1; m_lock = 1;
                        for (int i = 0; i < NPORT; i++) m_res[i] = 0;
                    end else exp = 0;
                end
                default: ;
            endcase
            chk(m_op == 3 ? "R5 cond result" : "R4 read value", int'(rsp_data), exp);
            last_rsp[m_port] = int'(rsp_data);
            m_exec = 0;
        end
    end

    task automatic put(int p, int o, int w);
        pend_v[p]  = 1'b1;
        pend_op[p] = 2'(o);
        pend_wd[p] = 8'(w);
    endtask

    task automatic wait_idle();
        @(negedge clk); #2;
        while (pend_v != '0 || m_exec) begin
            @(negedge clk); #2;
        end
    endtask

    task automatic do1(int p, int o, int w);
        @(posedge clk); #1;
        put(p, o, w);
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < NPORT; i++) begin
            pend_op[i] = '0; pend_wd[i] = '0; last_rsp[i] = -1;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        // R1 reset state
        chk("R1 grant after reset", int'(gnt), 0);
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
        do1(0, 0, 0);
        chk("R1 word after reset", last_rsp[0], 0);
        // R6 conditional store with no linked load
        do1(1, 3, 0);
        chk("R6 cond without link", last_rsp[1], 0);
        do1(2, 0, 0);
        chk("R6 word unchanged", last_rsp[2], 0);
        // R4 / R5 take the lock
        do1(0, 2, 0);
        chk("R4 link reads free", last_rsp[0], 0);
        do1(0, 3, 0);
        chk("R5 cond success", last_rsp[0], 1);
        do1(1, 0, 0);
        chk("R5 word locked", last_rsp[1], 1);
        do1(0, 3, 0);
        chk("R5 reservation consumed", last_rsp[0], 0);
        // R7 race among three ports
        do1(0, 1, 0);
        @(posedge clk); #1;
        put(1, 2, 0); put(2, 2, 0); put(3, 2, 0);
        wait_idle();
        chk("R4 racer1 link", last_rsp[1], 0);
        chk("R4 racer3 link", last_rsp[3], 0);
        @(posedge clk); #1;
        put(1, 3, 0); put(2, 3, 0); put(3, 3, 0);
        wait_idle();
        chk("R7 single winner", last_rsp[1] + last_rsp[2] + last_rsp[3], 1);
        do1(0, 0, 0);
        chk("R7 word locked after race", last_rsp[0], 1);
        // R8 store clears others, keeps own
        do1(3, 1, 0);
        @(posedge clk); #1;
        put(1, 2, 0); put(2, 2, 0);
        wait_idle();
        do1(2, 1, 0);
        do1(1, 3, 0);
        chk("R8 other reservation cleared", last_rsp[1], 0);
        do1(2, 3, 0);
        chk("R8 own reservation kept", last_rsp[2], 1);
        do1(3, 1, 5);
        do1(0, 0, 0);
        chk("R8 stored data", last_rsp[0], 5);
        // R9 load keeps reservation and word
        do1(0, 2, 0);
        do1(1, 0, 0);
        chk("R9 load sees word", last_rsp[1], 5);
        do1(0, 3, 0);
        chk("R9 reservation survives load", last_rsp[0], 1);
        // R2 round robin with all ports requesting
        gq.delete();
        @(posedge clk); #1;
        for (int i = 0; i < NPORT; i++) put(i, 0, 0);
        wait_idle();
        chk("R2 grant count", gq.size(), NPORT);
        if (gq.size() == NPORT) begin
            for (int i = 1; i < NPORT; i++)
                chk("R2 rotation order", gq[i], (gq[i-1] + 1) % NPORT);
        end
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule